// File: doc/BRIEF.md
# Predicated Scalar Float Comparator

This unit compares two single-precision IEEE-754 values, operand A and operand B, under a 5-bit predicate code. The code selects one of sixteen relations, and its top bit chooses whether a quiet NaN is reported as an invalid operation. The relations cover equality, less-than, less-or-equal, their negations, the greater-than forms, the ordered and unordered tests, and constant true and false. The unit produces one boolean outcome, and a mode input selects how that outcome is packed into a 128-bit result word.

Operand A is a full 128-bit source, and its low 32 bits are the compared value. Operand B is a 32-bit value. In the two lane modes, a 32-bit mask of all ones or all zeros fills the low lane, and the upper 96 bits come from operand A. In mask mode, only bit 0 is used, and a writemask can force it to zero. The unit also reports two status flags: an invalid-operation flag and a denormal-input flag.

A request is taken when `in_valid` is high. The result and the flags are registered and appear on the following clock edge. They hold until the next request is taken.

Top module: `fcmp_pred_unit`

## Requirements
- R1: For predicate codes 0 to 15, the outcome is: 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less, 6 not-less-or-equal, 7 ordered, 8 equal-or-unordered, 9 not-greater-or-equal, 10 not-greater, 11 false, 12 equal-free-and-ordered (not-equal, false if unordered), 13 greater-or-equal, 14 greater, 15 true. Codes 0, 1, 2, 7, 11, 12, 13 and 14 are false when either operand is a NaN. Codes 3, 4, 5, 6, 8, 9, 10 and 15 are true when either operand is a NaN.
- R2: A code from 16 to 31 gives the same outcome as the code 16 lower. Its quiet/signaling attribute is inverted. The signaling codes are 1, 2, 5, 6, 9, 10, 13, 14, 16, 19, 20, 23, 24, 27, 28 and 31.
- R3: A value is a NaN when its exponent is all ones and its fraction is nonzero. A NaN is quiet when fraction bit 22 is 1 and signaling when that bit is 0. A pair is unordered when at least one operand is a NaN.
- R4: +0 and -0 compare equal. Non-NaN values are ordered by sign and magnitude: a negative value is below a positive one, and among negative values a larger magnitude is smaller.
- R5: Mode 0 (legacy) uses only predicate bits 2:0. Bits 31:0 of the result are 0xFFFFFFFF when the outcome is true and 0x00000000 when it is false. Bits 127:32 equal operand A bits 127:32.
- R6: Mode 1 (merge) uses all five predicate bits. The lane is formatted as in R5, and bits 127:32 are copied from operand A.
- R7: Mode 2 (mask) sets bit 0 to the outcome when `wmask_en` is 0 or `wmask_bit` is 1. Bit 0 is 0 when `wmask_en` is 1 and `wmask_bit` is 0. Bits 127:1 are always 0.
- R8: `flag_inv` is 1 when either operand is a signaling NaN.
- R9: `flag_inv` is also 1 when either operand is a quiet NaN and the effective predicate is signaling (R2).
- R10: `flag_den` is 1 when either operand has a zero exponent and a nonzero fraction.
- R11: A request with `in_valid` high produces its result, its flags and `out_valid` high one clock later. While `in_valid` is low, `out_valid` is 0 on the next cycle and the result and flags hold their values.
- R12: While `rst_n` is low, `out_valid`, `res_vec`, `flag_inv` and `flag_den` are all 0.
- R13: Mode 3 is inert. Its result is all zeros and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe and register enable |
| mode | input | 2 | Result format: 0 legacy, 1 merge, 2 mask, 3 inert |
| pred | input | 5 | Predicate code |
| src_a | input | 128 | Operand A; the low 32 bits are compared, the upper bits are merged |
| src_b | input | 32 | Operand B |
| wmask_en | input | 1 | Enables the writemask in mask mode |
| wmask_bit | input | 1 | Writemask bit |
| out_valid | output | 1 | Result registered from a request |
| res_vec | output | 128 | Formatted result |
| flag_inv | output | 1 | Invalid-operation status |
| flag_den | output | 1 | Denormal-input status |

## Verification
The bench builds the unit with its default parameters: an 8-bit exponent, a 23-bit fraction and a 128-bit result. These values make the quiet bit of the fraction, the all-ones exponent and the 96-bit merged upper field concrete values that a vector table can write by hand. The table covers every relation family, both NaN kinds under quiet and signaling codes, signed zeros, negative ordering and infinity. It also includes legacy-mode codes whose dropped upper bits would change the outcome, and all writemask combinations. Directed steps then cover the reset state, holding while idle, and the inert mode with a signaling NaN present.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int PRED_W = 5;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'd0,
    MODE_MERGE  = 2'd1,
    MODE_MASK   = 2'd2,
    MODE_OFF    = 2'd3
  } fcmp_mode_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
    logic is_denorm;
  } fcmp_class_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fcmp_class_t          cls
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             frac_nz;

  assign exp_f  = val[FP_W-2:MAN_W];
  assign frac_f = val[MAN_W-1:0];

  always_comb begin
    exp_ones      = &exp_f;
    exp_zero      = ~|exp_f;
    frac_nz       = |frac_f;
    cls.is_nan    = exp_ones & frac_nz;
    cls.is_qnan   = exp_ones & frac_nz & frac_f[MAN_W-1];
    cls.is_snan   = exp_ones & frac_nz & ~frac_f[MAN_W-1];
    cls.is_zero   = exp_zero & ~frac_nz;
    cls.is_denorm = exp_zero & frac_nz;
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_val,
  input  logic [EXP_W+MAN_W:0] b_val,
  input  logic                 a_nan,
  input  logic                 b_nan,
  input  logic                 a_zero,
  input  logic                 b_zero,
  output logic                 rel_eq,
  output logic                 rel_lt,
  output logic                 rel_unord
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic [FP_W-2:0] mag_a;
  logic [FP_W-2:0] mag_b;
  logic            sgn_a;
  logic            sgn_b;
  logic            both_zero;

  assign mag_a = a_val[FP_W-2:0];
  assign mag_b = b_val[FP_W-2:0];
  assign sgn_a = a_val[FP_W-1];
  assign sgn_b = b_val[FP_W-1];

  always_comb begin
    rel_unord = a_nan | b_nan;
    both_zero = a_zero & b_zero;
    rel_eq    = ~rel_unord & ((a_val == b_val) | both_zero);
    if (rel_unord || both_zero) begin
      rel_lt = 1'b0;
    end else if (sgn_a != sgn_b) begin
      rel_lt = sgn_a;
    end else if (!sgn_a) begin
      rel_lt = mag_a < mag_b;
    end else begin
      rel_lt = mag_a > mag_b;
    end
  end
endmodule

// File: rtl/fcmp_pred_eval.sv
module fcmp_pred_eval
  import fcmp_pkg::*;
(
  input  logic [PRED_W-1:0] pred_eff,
  input  logic              rel_eq,
  input  logic              rel_lt,
  input  logic              rel_unord,
  input  logic              any_snan,
  input  logic              any_qnan,
  output logic              hit,
  output logic              invalid
);
  logic base_rel;
  logic nan_term;
  logic sig_pred;

  always_comb begin
    unique case (pred_eff[1:0])
      2'd0:    base_rel = rel_eq;
      2'd1:    base_rel = rel_lt;
      2'd2:    base_rel = rel_eq | rel_lt;
      default: base_rel = 1'b0;
    endcase
    nan_term = rel_unord & (pred_eff[3] ^ (pred_eff[1:0] == 2'd3));
    hit      = (base_rel | nan_term) ^ pred_eff[2];
    sig_pred = ((pred_eff[1:0] == 2'd1) | (pred_eff[1:0] == 2'd2)) ^ pred_eff[4];
    invalid  = any_snan | (any_qnan & sig_pred);
  end
endmodule

// File: rtl/fcmp_format.sv
module fcmp_format
  import fcmp_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int FP_W  = 32
) (
  input  fcmp_mode_e       mode_sel,
  input  logic             hit,
  input  logic             wmask_en,
  input  logic             wmask_bit,
  input  logic [VEC_W-1:0] src_a,
  output logic [VEC_W-1:0] res_d
);
  logic [FP_W-1:0] lane;
  logic            kept;

  always_comb begin
    lane = {FP_W{hit}};
    kept = hit & (~wmask_en | wmask_bit);
    unique case (mode_sel)
      MODE_LEGACY, MODE_MERGE: res_d = {src_a[VEC_W-1:FP_W], lane};
      MODE_MASK:               res_d = {{(VEC_W-1){1'b0}}, kept};
      default:                 res_d = '0;
    endcase
  end
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic [4:0]           pred,
  input  logic [VEC_W-1:0]     src_a,
  input  logic [EXP_W+MAN_W:0] src_b,
  input  logic                 wmask_en,
  input  logic                 wmask_bit,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     res_vec,
  output logic                 flag_inv,
  output logic                 flag_den
);
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int N_OPND = 2;

  fcmp_mode_e        mode_sel;
  logic [FP_W-1:0]   opnd [N_OPND];
  fcmp_class_t       cls  [N_OPND];
  logic [PRED_W-1:0] pred_eff;
  logic              rel_eq, rel_lt, rel_unord;
  logic              hit, invalid_raw;
  logic              any_snan, any_qnan, any_den;
  logic [VEC_W-1:0]  res_d;
  logic              inv_d, den_d;
  logic              active;

  logic [VEC_W-1:0]  res_q;
  logic              inv_q, den_q, vld_q;

  assign mode_sel = fcmp_mode_e'(mode);
  assign opnd[0]  = src_a[FP_W-1:0];
  assign opnd[1]  = src_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val (opnd[gi]),
      .cls (cls[gi])
    );
  end

  fcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a_val     (opnd[0]),
    .b_val     (opnd[1]),
    .a_nan     (cls[0].is_nan),
    .b_nan     (cls[1].is_nan),
    .a_zero    (cls[0].is_zero),
    .b_zero    (cls[1].is_zero),
    .rel_eq    (rel_eq),
    .rel_lt    (rel_lt),
    .rel_unord (rel_unord)
  );

  always_comb begin
    pred_eff = (mode_sel == MODE_LEGACY) ? {2'b00, pred[2:0]} : pred;
    any_snan = cls[0].is_snan | cls[1].is_snan;
    any_qnan = cls[0].is_qnan | cls[1].is_qnan;
    any_den  = cls[0].is_denorm | cls[1].is_denorm;
  end

  fcmp_pred_eval u_eval (
    .pred_eff  (pred_eff),
    .rel_eq    (rel_eq),
    .rel_lt    (rel_lt),
    .rel_unord (rel_unord),
    .any_snan  (any_snan),
    .any_qnan  (any_qnan),
    .hit       (hit),
    .invalid   (invalid_raw)
  );

  fcmp_format #(.VEC_W(VEC_W), .FP_W(FP_W)) u_fmt (
    .mode_sel  (mode_sel),
    .hit       (hit),
    .wmask_en  (wmask_en),
    .wmask_bit (wmask_bit),
    .src_a     (src_a),
    .res_d     (res_d)
  );

  always_comb begin
    active = (mode_sel != MODE_OFF);
    inv_d  = active & invalid_raw;
    den_d  = active & any_den;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      den_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        inv_q <= inv_d;
        den_q <= den_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign res_vec   = res_q;
  assign flag_inv  = inv_q;
  assign flag_den  = den_q;
endmodule

// File: rtl/fcmp_pred_unit_chk.sv
module fcmp_pred_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int VEC_W = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           mode,
  input logic [4:0]           pred,
  input logic [VEC_W-1:0]     src_a,
  input logic [EXP_W+MAN_W:0] src_b,
  input logic                 wmask_en,
  input logic                 wmask_bit,
  input logic                 out_valid,
  input logic [VEC_W-1:0]     res_vec,
  input logic                 flag_inv,
  input logic                 flag_den
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic a_sig_nan, b_sig_nan;
  assign a_sig_nan = (&src_a[FP_W-2:MAN_W]) & ~src_a[MAN_W-1] & (|src_a[MAN_W-2:0]);
  assign b_sig_nan = (&src_b[FP_W-2:MAN_W]) & ~src_b[MAN_W-1] & (|src_b[MAN_W-2:0]);

  AST_VALID_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_vec) && $stable(flag_inv) && $stable(flag_den))); // R11
  AST_LANE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] == 1'b0) |=>
      (res_vec[FP_W-1:0] == '0 || res_vec[FP_W-1:0] == '1)); // R5
  AST_UPPER_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] == 1'b0) |=>
      res_vec[VEC_W-1:FP_W] == $past(src_a[VEC_W-1:FP_W])); // R6
  AST_MASK_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2) |=> res_vec[VEC_W-1:1] == '0); // R7
  AST_WMASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && wmask_en && !wmask_bit) |=> !res_vec[0]); // R7
  AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'd3 && (a_sig_nan || b_sig_nan)) |=> flag_inv); // R8
  AST_OFF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3) |=> (res_vec == '0 && !flag_inv && !flag_den)); // R13
endmodule

bind fcmp_pred_unit fcmp_pred_unit_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .VEC_W(VEC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .pred      (pred),
  .src_a     (src_a),
  .src_b     (src_b),
  .wmask_en  (wmask_en),
  .wmask_bit (wmask_bit),
  .out_valid (out_valid),
  .res_vec   (res_vec),
  .flag_inv  (flag_inv),
  .flag_den  (flag_den)
);

// File: tb/tb_fcmp_pred_unit.sv
module tb_fcmp_pred_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 35;

  localparam logic [31:0] P1  = 32'h3F80_0000;
  localparam logic [31:0] P2  = 32'h4000_0000;
  localparam logic [31:0] M1  = 32'hBF80_0000;
  localparam logic [31:0] M2  = 32'hC000_0000;
  localparam logic [31:0] PZ  = 32'h0000_0000;
  localparam logic [31:0] MZ  = 32'h8000_0000;
  localparam logic [31:0] QN  = 32'h7FC0_0000;
  localparam logic [31:0] SN  = 32'h7F80_0001;
  localparam logic [31:0] INF = 32'h7F80_0000;
  localparam logic [31:0] DN  = 32'h0000_0001;

  // {mode, pred, a, b, wmask_en, wmask_bit, exp_hit, exp_inv, exp_den}
  localparam logic [75:0] VEC [N_VEC] = '{
    {2'd1, 5'd0,  P1, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 eq
    {2'd1, 5'd1,  P1, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 lt
    {2'd1, 5'd1,  P2, P1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 lt false
    {2'd1, 5'd2,  P2, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 le
    {2'd1, 5'd3,  QN, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 unordered
    {2'd1, 5'd4,  QN, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 neq on NaN
    {2'd1, 5'd5,  QN, P1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 nlt signaling
    {2'd1, 5'd7,  P1, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 ordered
    {2'd1, 5'd8,  QN, QN, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 eq-or-unord
    {2'd1, 5'd9,  P1, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 nge
    {2'd1, 5'd10, P2, P1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 ngt
    {2'd1, 5'd11, P1, P1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 false
    {2'd1, 5'd12, QN, P1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 neq ordered
    {2'd1, 5'd13, P2, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 ge
    {2'd1, 5'd14, P1, P1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 gt equal
    {2'd1, 5'd15, QN, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 true
    {2'd1, 5'd16, QN, P1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 eq signaling
    {2'd1, 5'd17, QN, P1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 lt quiet
    {2'd1, 5'd31, QN, P1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 true signaling
    {2'd1, 5'd0,  PZ, MZ, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 signed zeros
    {2'd1, 5'd1,  M2, M1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 negatives
    {2'd1, 5'd1,  M1, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 sign
    {2'd1, 5'd1,  MZ, PZ, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 -0 < +0 false
    {2'd1, 5'd14, INF, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 infinity
    {2'd1, 5'd3,  SN, P1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 snan
    {2'd1, 5'd0,  DN, DN, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R10 denormal
    {2'd1, 5'd2,  P1, DN, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 denormal b
    {2'd0, 5'd12, QN, P1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 legacy 12->4
    {2'd0, 5'd17, QN, P1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 legacy 17->1
    {2'd0, 5'd2,  P1, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 legacy le
    {2'd2, 5'd1,  P1, P2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 mask kept
    {2'd2, 5'd1,  P1, P2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 mask blocked
    {2'd2, 5'd1,  P1, P2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 mask disabled
    {2'd2, 5'd1,  P1, SN, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 R8 flags under mask
    {2'd3, 5'd15, SN, DN, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R13 inert
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   mode;
  logic [4:0]   pred;
  logic [127:0] src_a;
  logic [31:0]  src_b;
  logic         wmask_en;
  logic         wmask_bit;
  logic         out_valid;
  logic [127:0] res_vec;
  logic         flag_inv;
  logic         flag_den;

  int n_tests;
  int n_fail;
  logic [127:0] last_exp;

  fcmp_pred_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .pred      (pred),
    .src_a     (src_a),
    .src_b     (src_b),
    .wmask_en  (wmask_en),
    .wmask_bit (wmask_bit),
    .out_valid (out_valid),
    .res_vec   (res_vec),
    .flag_inv  (flag_inv),
    .flag_den  (flag_den)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_vec(input logic [1:0] md, input logic [95:0] hi,
                                              input logic h);
    case (md)
      2'd0, 2'd1: return {hi, {32{h}}};
      2'd2:       return {127'd0, h};
      default:    return 128'd0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    mode      = 2'd1;
    pred      = 5'd0;
    src_a     = '1;
    src_b     = '1;
    wmask_en  = 1'b0;
    wmask_bit = 1'b0;

    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check("R12 out_valid", {127'd0, out_valid}, 128'd0);
    check("R12 res_vec", res_vec, 128'd0);
    check("R12 flags", {126'd0, flag_inv, flag_den}, 128'd0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      logic [1:0]  md;
      logic [95:0] hi;
      logic [75:0] v;
      v         = VEC[i];
      md        = v[75:74];
      hi        = {32'h1234_5678 ^ i, 32'hDEAD_BEEF, 32'h0F0F_00F0};
      mode      = md;
      pred      = v[73:69];
      src_a     = {hi, v[68:37]};
      src_b     = v[36:5];
      wmask_en  = v[4];
      wmask_bit = v[3];
      in_valid  = 1'b1;
      @(negedge clk);
      last_exp  = expect_vec(md, hi, v[2]);
      check($sformatf("R11 valid vec%0d", i), {127'd0, out_valid}, 128'd1);
      check($sformatf("R1-table result vec%0d", i), res_vec, last_exp);
      check($sformatf("R9 inv vec%0d", i), {127'd0, flag_inv}, {127'd0, v[1]});
      check($sformatf("R10 den vec%0d", i), {127'd0, flag_den}, {127'd0, v[0]});
    end

    // R11: idle cycle holds result and flags, drops out_valid
    in_valid = 1'b0;
    mode     = 2'd1;
    pred     = 5'd15;
    src_a    = '0;
    src_b    = SN;
    @(negedge clk);
    check("R11 idle valid", {127'd0, out_valid}, 128'd0);
    check("R11 idle hold", res_vec, last_exp);
    check("R11 idle flags", {126'd0, flag_inv, flag_den}, 128'd0);

    // R6: merge upper field with distinctive pattern, pred 11 (false)
    src_a    = {96'hFEDC_BA98_7654_3210_0011_2233, P1};
    src_b    = P2;
    pred     = 5'd11;
    in_valid = 1'b1;
    @(negedge clk);
    check("R6 merge upper", res_vec, {96'hFEDC_BA98_7654_3210_0011_2233, 32'h0});
    in_valid = 1'b0;

    // R12: reset asserted again clears registered state
    rst_n = 1'b0;
    #1;
    check("R12 async clear", res_vec, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule